// File: doc/BRIEF.md
# Test Access Port State Controller with Stop-Mode Interlock

This block follows the sixteen-state boundary-scan controller on the rising edge of the test clock. The test mode select input chooses the branch taken from each state. The block reports the current state and a flag that is high while the test logic is transparent, which means the controller is in the test-logic-reset state. It also decides whether the processor core may enter low-power stop mode. Stop is granted only while the controller rests in test-logic-reset. If the controller moves away from that state, the grant is withdrawn.

A power-on reset input forces the controller into test-logic-reset at once, and the controller ignores the mode select input while that reset is asserted. The release of power-on reset is resynchronised to the test clock, so the first transition can only happen a fixed number of edges after release. The test clock is never blocked during stop, and the controller keeps tracking the mode select input while the chip is stopped.

Top module: `tap_pwr_ctrl`

## Requirements
- R1: While `por` is high, `state_o` is 0 (test-logic-reset), whatever `tms` does. Raising `por` forces state 0 at once, without waiting for a clock edge.
- R2: With the default `SYNC_STAGES` of 2, the first two rising `tck` edges after `por` falls leave the state at 0. The third edge is the first one that can move the state.
- R3: State codes are TLR=0, RTI=1, SEL_DR=2, CAP_DR=3, SHIFT_DR=4, EXIT1_DR=5, PAUSE_DR=6, EXIT2_DR=7, UPD_DR=8, SEL_IR=9, CAP_IR=10, SHIFT_IR=11, EXIT1_IR=12, PAUSE_IR=13, EXIT2_IR=14, UPD_IR=15. Each state moves to a fixed next state on each `tms` value, on the rising edge of `tck`, as follows:
  - TLR goes to TLR when `tms` is 1 and to RTI when `tms` is 0.
  - RTI goes to SEL_DR on 1 and stays in RTI on 0.
  - SEL_DR goes to SEL_IR on 1 and to CAP_DR on 0.
  - SEL_IR goes to TLR on 1 and to CAP_IR on 0.
  - CAP goes to EXIT1 on 1 and to SHIFT on 0.
  - SHIFT goes to EXIT1 on 1 and stays in SHIFT on 0.
  - EXIT1 goes to UPD on 1 and to PAUSE on 0.
  - PAUSE goes to EXIT2 on 1 and stays in PAUSE on 0.
  - EXIT2 goes to UPD on 1 and to SHIFT on 0.
  - UPD goes to SEL_DR on 1 and to RTI on 0.
  - The CAP, SHIFT, EXIT1, PAUSE, EXIT2 and UPD rules apply to both the DR branch and the IR branch, each within its own branch. The one exception is UPD, which always returns to SEL_DR or RTI.
- R4: Starting from any of the sixteen states, five consecutive rising edges with `tms` high end in state 0.
- R5: Once the state is 0, it stays 0 for as long as `tms` is high.
- R6: `tlr_o` is high exactly when `state_o` is 0.
- R7: `stop_grant_o` equals `stop_req` AND `tlr_o`, with no clock delay. A request is refused in RTI, in SHIFT_DR and in every other state that is not 0.
- R8: If `stop_req` stays high and the state leaves 0, `stop_grant_o` falls after that same edge. The state keeps following `tms` while a grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; the state moves on its rising edge |
| por | input | 1 | Active-high power-on reset; asserts asynchronously, release is synchronised |
| tms | input | 1 | Test mode select; picks the branch at each state |
| stop_req | input | 1 | Low-power stop request from the core |
| state_o | output | 4 | Current controller state, coded as in R3 |
| tlr_o | output | 1 | High while the controller is in test-logic-reset |
| stop_grant_o | output | 1 | Permission to enter or hold low-power stop |

## Verification
A state change caused by `tms` appears on `state_o` one rising edge after `tms` is applied. The grant and the reset flag follow the state with no extra delay, and a grant responds to `stop_req` in the same cycle. Power-on reset acts on the state immediately. Its release allows movement only on the third edge. The bench drives inputs on the falling edge and samples one time unit after the rising edge, so each result is read in the cycle it is due. The asynchronous reset is checked between edges, before any clock can act.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int TAP_STATE_W = 4;

    typedef enum logic [TAP_STATE_W-1:0] {
        ST_TLR      = 4'd0,
        ST_RTI      = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SHIFT_DR = 4'd4,
        ST_EXIT1_DR = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EXIT2_DR = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SHIFT_IR = 4'd11,
        ST_EXIT1_IR = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EXIT2_IR = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

endpackage

// File: rtl/tap_por_sync.sv
// Power-on reset conditioner: asserts asynchronously, releases after STAGES tck edges.
module tap_por_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    output logic rst_n
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or posedge por) begin
                if (por) chain_q <= 1'b0;
                else     chain_q <= 1'b1;
            end
        end else begin : g_multi
            always_ff @(posedge clk or posedge por) begin
                if (por) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tap_fsm.sv
// Sixteen-state controller: state register, next-state logic, decoded flag.
module tap_fsm
    import tap_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tms,
    output logic [TAP_STATE_W-1:0] state,
    output logic                   in_tlr
);
    tap_state_e cur_q, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= ST_TLR;
        else        cur_q <= nxt;
    end

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            ST_TLR:      nxt = tms ? ST_TLR      : ST_RTI;
            ST_RTI:      nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            ST_SEL_IR:   nxt = tms ? ST_TLR      : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_RTI;
            default:     nxt = ST_TLR;
        endcase
    end

    always_comb begin
        state  = cur_q;
        in_tlr = (cur_q == ST_TLR);
    end
endmodule

// File: rtl/tap_stop_gate.sv
// Stop-mode interlock: permission only while the test logic is transparent.
module tap_stop_gate (
    input  logic req,
    input  logic transparent,
    output logic grant
);
    always_comb grant = req & transparent;
endmodule

// File: rtl/tap_pwr_ctrl.sv
module tap_pwr_ctrl
    import tap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   tck,
    input  logic                   por,
    input  logic                   tms,
    input  logic                   stop_req,
    output logic [TAP_STATE_W-1:0] state_o,
    output logic                   tlr_o,
    output logic                   stop_grant_o
);
    logic fsm_rst_n;

    tap_por_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (tck),
        .por   (por),
        .rst_n (fsm_rst_n)
    );

    tap_fsm i_fsm (
        .clk    (tck),
        .rst_n  (fsm_rst_n),
        .tms    (tms),
        .state  (state_o),
        .in_tlr (tlr_o)
    );

    tap_stop_gate i_gate (
        .req         (stop_req),
        .transparent (tlr_o),
        .grant       (stop_grant_o)
    );
endmodule

// File: rtl/tap_pwr_ctrl_chk.sv
module tap_pwr_ctrl_chk
    import tap_pkg::*;
(
    input logic                   tck,
    input logic                   por,
    input logic                   tms,
    input logic                   stop_req,
    input logic [TAP_STATE_W-1:0] state_o,
    input logic                   tlr_o,
    input logic                   stop_grant_o
);
    logic [2:0] ones_q;

    always_ff @(posedge tck or posedge por) begin
        if (por)             ones_q <= '0;
        else if (!tms)       ones_q <= '0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    AST_POR_HOLDS_TLR: assert property (@(posedge tck) por |-> (state_o == ST_TLR)); // R1
    AST_SHIFT_DR_HOLD: assert property (@(posedge tck) disable iff (por) (state_o == ST_SHIFT_DR) && !tms |=> (state_o == ST_SHIFT_DR)); // R3
    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (por) (ones_q >= 3'd4) && tms |=> tlr_o); // R4
    AST_TLR_STICKY: assert property (@(posedge tck) disable iff (por) tlr_o && tms |=> tlr_o); // R5
    AST_FLAG_MATCHES_STATE: assert property (@(posedge tck) tlr_o == (state_o == ST_TLR)); // R6
    AST_GRANT_NEEDS_TLR: assert property (@(posedge tck) stop_grant_o |-> (state_o == ST_TLR)); // R7
    AST_GRANT_WHEN_ALLOWED: assert property (@(posedge tck) stop_req && (state_o == ST_TLR) |-> stop_grant_o); // R7
endmodule

bind tap_pwr_ctrl tap_pwr_ctrl_chk i_chk (
    .tck          (tck),
    .por          (por),
    .tms          (tms),
    .stop_req     (stop_req),
    .state_o      (state_o),
    .tlr_o        (tlr_o),
    .stop_grant_o (stop_grant_o)
);

// File: tb/test_tap_pwr_ctrl.sv
module test_tap_pwr_ctrl;
    localparam int TCK_PERIOD = 10;
    localparam int NVEC = 44;

    // {tms, expected state after the edge}
    localparam logic [4:0] VEC [NVEC] = '{
        5'h10, 5'h01, 5'h01, 5'h12, 5'h03, 5'h04, 5'h04, 5'h15, 5'h06, 5'h06,
        5'h17, 5'h04, 5'h15, 5'h18, 5'h12, 5'h03, 5'h15, 5'h06, 5'h17, 5'h18,
        5'h01, 5'h12, 5'h19, 5'h0A, 5'h0B, 5'h0B, 5'h1C, 5'h0D, 5'h0D, 5'h1E,
        5'h0B, 5'h1C, 5'h1F, 5'h12, 5'h19, 5'h0A, 5'h1C, 5'h0D, 5'h1E, 5'h1F,
        5'h01, 5'h12, 5'h19, 5'h10
    };

    // path from state 0 to each state, bit 0 applied first
    localparam logic [7:0] PATH_BITS [16] = '{
        8'b0000000, 8'b0000000, 8'b0000010, 8'b0000010,
        8'b0000010, 8'b0001010, 8'b0001010, 8'b0101010,
        8'b0011010, 8'b0000110, 8'b0000110, 8'b0000110,
        8'b0010110, 8'b0010110, 8'b1010110, 8'b0110110
    };
    localparam int PATH_LEN [16] = '{0, 1, 2, 3, 4, 4, 5, 6, 5, 3, 4, 5, 5, 6, 7, 6};

    logic       tck = 1'b0;
    logic       por = 1'b1;
    logic       tms = 1'b0;
    logic       stop_req = 1'b0;
    logic [3:0] state_o;
    logic       tlr_o;
    logic       stop_grant_o;

    int checks = 0;
    int errors = 0;

    tap_pwr_ctrl i_tap_pwr_ctrl (
        .tck          (tck),
        .por          (por),
        .tms          (tms),
        .stop_req     (stop_req),
        .state_o      (state_o),
        .tlr_o        (tlr_o),
        .stop_grant_o (stop_grant_o)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic t);
        @(negedge tck);
        tms = t;
        @(posedge tck);
        #1;
    endtask

    task automatic five_ones();
        for (int k = 0; k < 5; k++) step(1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge tck);
        errors++;
        $display("FAIL R3: watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int bad;

        // R1: held in reset while tms toggles
        #1;
        check(state_o == 4'd0 && tlr_o && !stop_grant_o, "R1 reset state", state_o, 0);
        for (int k = 0; k < 3; k++) begin
            step(k[0]);
            check(state_o == 4'd0, "R1 tms ignored under por", state_o, 0);
        end

        // R2: release, tms low; moves only on third edge
        @(negedge tck);
        por = 1'b0;
        tms = 1'b0;
        @(posedge tck); #1;
        check(state_o == 4'd0, "R2 edge 1 after release", state_o, 0);
        step(1'b0);
        check(state_o == 4'd0, "R2 edge 2 after release", state_o, 0);
        step(1'b0);
        check(state_o == 4'd1, "R2 edge 3 after release", state_o, 1);
        five_ones();
        check(state_o == 4'd0, "R4 recover before table", state_o, 0);

        // R3/R6: table walk
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4]);
            check(state_o == VEC[i][3:0], "R3 transition", state_o, int'(VEC[i][3:0]));
            check(tlr_o == (VEC[i][3:0] == 4'd0), "R6 tlr flag", tlr_o, int'(VEC[i][3:0] == 4'd0));
        end

        // R4: five ones from every state
        for (int s = 0; s < 16; s++) begin
            five_ones();
            for (int b = 0; b < PATH_LEN[s]; b++) step(PATH_BITS[s][b]);
            check(state_o == s[3:0], "R3 path to state", state_o, s);
            five_ones();
            check(state_o == 4'd0, "R4 five ones from state", state_o, 0);
        end

        // R5: tms held high keeps tlr
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            step(1'b1);
            if (state_o != 4'd0) bad++;
        end
        check(bad == 0, "R5 stays in tlr", bad, 0);

        // R7/R8: stop interlock
        @(negedge tck);
        stop_req = 1'b1;
        #1;
        check(stop_grant_o == 1'b1, "R7 grant in tlr", stop_grant_o, 1);
        step(1'b0);
        check(state_o == 4'd1 && !stop_grant_o, "R8 grant drops entering RTI", stop_grant_o, 0);
        step(1'b0);
        check(!stop_grant_o, "R7 refused in RTI", stop_grant_o, 0);
        step(1'b1); step(1'b0); step(1'b0);
        check(state_o == 4'd4, "R8 follows tms while requested", state_o, 4);
        check(!stop_grant_o, "R7 refused in SHIFT_DR", stop_grant_o, 0);
        five_ones();
        check(stop_grant_o == 1'b1, "R7 grant back in tlr", stop_grant_o, 1);
        @(negedge tck);
        stop_req = 1'b0;
        #1;
        check(!stop_grant_o, "R7 no request no grant", stop_grant_o, 0);

        // R1: asynchronous por mid-run
        step(1'b0); step(1'b1); step(1'b0); step(1'b0);
        check(state_o == 4'd4, "R3 reach SHIFT_DR", state_o, 4);
        @(negedge tck);
        tms = 1'b0;
        #2 por = 1'b1;
        #1;
        check(state_o == 4'd0, "R1 async por", state_o, 0);
        step(1'b0);
        check(state_o == 4'd0, "R1 held under por", state_o, 0);
        @(negedge tck);
        por = 1'b0;
        @(posedge tck); #1;
        step(1'b0);
        step(1'b0);
        check(state_o == 4'd1, "R2 third edge after second release", state_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule